// File: doc/BRIEF.md
# DRAM Command Turnaround Delay Calculator

This block turns a small set of static memory timing values into the three spacings a DRAM command scheduler needs for its next decision. The spacings are the gap between two column commands, the gap between two row activations, and the gap from a column command to the precharge of the same bank. It looks at the type of the previous and current column command (read or write), the memory family in use and, for the bank-grouped family, whether the next access moves to another bank group. From these it picks and combines the timing inputs.

The computation is purely arithmetic. One register stage holds the results, so every output reflects the inputs presented one clock edge earlier. The block keeps no history and makes no scheduling decision of its own. The burst duration in clocks is the burst length divided by the data rate, and the data rate is either single or double.

Top module: `ta_turnaround_calc`

## Requirements
- R1: When the previous and current column commands have the same type, `col_gap` equals the column-to-column time. For family code 4 (bank-grouped) this is `tccd_s` if `grp_switch`=1 and `tccd_l` otherwise. Every other family uses `tccd_l`.
- R2: For a write (`prev_wr`=1) followed by a read (`cur_wr`=0), `col_gap` = `wl` + burst + write-to-read time. The bank-grouped family takes `twtr_s` or `twtr_l` by `grp_switch`, and the other families take `twtr_l`. Family 1 adds one cycle and family 5 removes one cycle.
- R3: For a read followed by a write, `col_gap` = `rl` + burst + 2 − `wl`, held at zero when that value would be negative.
- R4: `act_gap` is `trrd_s` for family 4 with `grp_switch`=1, and `trrd_l` in every other valid case.
- R5: When the current command is a read, `pre_gap` is derived from the family code as follows. Codes 0 and 5 give the burst. Code 1 gives burst + max(0, `trtp` − 2). Code 2 gives `al` + burst + max(`trtp`, 2) − 2. Codes 3 and 4 give `trtp`.
- R6: When the current command is a write, `pre_gap` = `wl` + burst + `twr`. Family 1 adds one cycle and family 5 removes one cycle.
- R7: Burst is `bl` shifted right by one when `dbl_rate`=1, and `bl` unchanged when `dbl_rate`=0.
- R8: Family codes 6 and 7 set `fam_err`=1 and force all three gaps to zero. Codes 0 to 5 give `fam_err`=0.
- R9: Outputs change one clock edge after their inputs. A synchronous low `rst_n` clears all gaps and `fam_err` at the next edge.
- R10: `grp_switch` has no effect for any family other than code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prev_wr | input | 1 | Previous column command is a write (1) or read (0) |
| cur_wr | input | 1 | Current column command is a write (1) or read (0) |
| fam_sel | input | 3 | Memory family code, 0 to 5 valid |
| grp_switch | input | 1 | Next access goes to another bank group |
| dbl_rate | input | 1 | Double data rate (1) or single (0) |
| wl | input | TW | Write latency |
| rl | input | TW | Read latency |
| bl | input | TW | Burst length in beats |
| tccd_s | input | TW | Column-to-column, other group |
| tccd_l | input | TW | Column-to-column, same group |
| twtr_s | input | TW | Write-to-read, other group |
| twtr_l | input | TW | Write-to-read, same group |
| trrd_s | input | TW | Activate-to-activate, other group |
| trrd_l | input | TW | Activate-to-activate, same group |
| trtp | input | TW | Read-to-precharge |
| twr | input | TW | Write recovery |
| al | input | TW | Additive latency |
| col_gap | output | OW | Column command turnaround |
| act_gap | output | OW | Activate spacing |
| pre_gap | output | OW | Column command to precharge |
| fam_err | output | 1 | Family code not supported |

## Verification
The assertions compare each gap against the timing input sampled on the previous edge. They rely on the timing inputs staying unchanged for at least one cycle around each operand change, so the bench sets them once and changes them only between groups of checks. The assertions also rely on the sums fitting in OW bits. The stimulus keeps every timing value small enough that the widest sum, `wl` plus a full burst plus `twr` plus one, stays far below that limit.

// File: rtl/ta_pkg.sv
// Package: family codes and shared helpers for the turnaround calculator.
// Assumes the family code is three bits wide; codes above FAM_WIDE_SDR are invalid.
package ta_pkg;

    localparam int FAM_W = 3;

    typedef enum logic [FAM_W-1:0] {
        FAM_LP_GEN1  = 3'd0,
        FAM_LP_GEN23 = 3'd1,
        FAM_STD_GEN2 = 3'd2,
        FAM_STD_GEN3 = 3'd3,
        FAM_BANKGRP  = 3'd4,
        FAM_WIDE_SDR = 3'd5
    } fam_e;

    // True when the code names a supported family.
    function automatic logic fam_valid(input logic [FAM_W-1:0] code);
        return code <= FAM_W'(FAM_WIDE_SDR);
    endfunction

endpackage

// File: rtl/ta_col_gap.sv
// Column-to-column turnaround and activate spacing.
// Assumes the burst input is already divided by the data rate.
module ta_col_gap
    import ta_pkg::*;
#(
    parameter int TW = 6,
    parameter int OW = 8
) (
    input  logic          prev_wr,
    input  logic          cur_wr,
    input  fam_e          fam,
    input  logic          grp_switch,
    input  logic [TW-1:0] wl,
    input  logic [TW-1:0] rl,
    input  logic [TW-1:0] burst,
    input  logic [TW-1:0] tccd_s,
    input  logic [TW-1:0] tccd_l,
    input  logic [TW-1:0] twtr_s,
    input  logic [TW-1:0] twtr_l,
    input  logic [TW-1:0] trrd_s,
    input  logic [TW-1:0] trrd_l,
    output logic [OW-1:0] col_gap,
    output logic [OW-1:0] act_gap
);
    localparam int SW = OW + 2;

    logic          use_short;
    logic [SW-1:0] ccd_v, wtr_v, rrd_v, w2r_v, r2w_pos, wl_x, r2w_v, col_v;

    // Pick short or long variants from the bank-group state.
    always_comb begin
        use_short = (fam == FAM_BANKGRP) && grp_switch;
        ccd_v     = use_short ? SW'(tccd_s) : SW'(tccd_l);
        wtr_v     = use_short ? SW'(twtr_s) : SW'(twtr_l);
        rrd_v     = use_short ? SW'(trrd_s) : SW'(trrd_l);
    end

    // Write-to-read delay with per-family one-cycle corrections.
    always_comb begin
        w2r_v = SW'(wl) + SW'(burst) + wtr_v;
        if (fam == FAM_LP_GEN23) begin
            w2r_v = w2r_v + SW'(1);
        end else if (fam == FAM_WIDE_SDR && w2r_v != '0) begin
            w2r_v = w2r_v - SW'(1);
        end
    end

    // Read-to-write delay, held at zero if write latency dominates.
    always_comb begin
        r2w_pos = SW'(rl) + SW'(burst) + SW'(2);
        wl_x    = SW'(wl);
        r2w_v   = (r2w_pos > wl_x) ? (r2w_pos - wl_x) : '0;
    end

    // Choose the turnaround by command-type pair.
    always_comb begin
        if (prev_wr == cur_wr) begin
            col_v = ccd_v;
        end else if (prev_wr) begin
            col_v = w2r_v;
        end else begin
            col_v = r2w_v;
        end
        col_gap = col_v[OW-1:0];
        act_gap = rrd_v[OW-1:0];
    end

endmodule

// File: rtl/ta_pre_gap.sv
// Column-command-to-precharge delay for reads and writes.
// Assumes the burst input is already divided by the data rate.
module ta_pre_gap
    import ta_pkg::*;
#(
    parameter int TW = 6,
    parameter int OW = 8
) (
    input  logic          cur_wr,
    input  fam_e          fam,
    input  logic [TW-1:0] wl,
    input  logic [TW-1:0] burst,
    input  logic [TW-1:0] trtp,
    input  logic [TW-1:0] twr,
    input  logic [TW-1:0] al,
    output logic [OW-1:0] pre_gap
);
    localparam int SW = OW + 2;

    logic [SW-1:0] rtp_x, rd_v, wr_v, sel_v;

    // Read-to-precharge by family.
    always_comb begin
        rtp_x = SW'(trtp);
        unique case (fam)
            FAM_LP_GEN1, FAM_WIDE_SDR: rd_v = SW'(burst);
            FAM_LP_GEN23: rd_v = SW'(burst) + ((rtp_x > SW'(2)) ? (rtp_x - SW'(2)) : '0);
            FAM_STD_GEN2: rd_v = SW'(al) + SW'(burst) + ((rtp_x > SW'(2)) ? rtp_x : SW'(2)) - SW'(2);
            default:      rd_v = rtp_x;
        endcase
    end

    // Write-to-precharge with per-family one-cycle corrections.
    always_comb begin
        wr_v = SW'(wl) + SW'(burst) + SW'(twr);
        if (fam == FAM_LP_GEN23) begin
            wr_v = wr_v + SW'(1);
        end else if (fam == FAM_WIDE_SDR && wr_v != '0) begin
            wr_v = wr_v - SW'(1);
        end
    end

    // Select by current command type.
    always_comb begin
        sel_v   = cur_wr ? wr_v : rd_v;
        pre_gap = sel_v[OW-1:0];
    end

endmodule

// File: rtl/ta_pipe_reg.sv
// Output register stage with synchronous active-low clear.
// Assumes nothing about the data; width is a parameter.
module ta_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the next value or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ta_turnaround_calc.sv
// Top: computes column turnaround, activate spacing and precharge delay,
// then registers them. Assumes timing inputs are static between operand changes
// and that unsupported family codes should zero all gaps and raise fam_err.
module ta_turnaround_calc
    import ta_pkg::*;
#(
    parameter int TW = 6,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prev_wr,
    input  logic          cur_wr,
    input  logic [2:0]    fam_sel,
    input  logic          grp_switch,
    input  logic          dbl_rate,
    input  logic [TW-1:0] wl,
    input  logic [TW-1:0] rl,
    input  logic [TW-1:0] bl,
    input  logic [TW-1:0] tccd_s,
    input  logic [TW-1:0] tccd_l,
    input  logic [TW-1:0] twtr_s,
    input  logic [TW-1:0] twtr_l,
    input  logic [TW-1:0] trrd_s,
    input  logic [TW-1:0] trrd_l,
    input  logic [TW-1:0] trtp,
    input  logic [TW-1:0] twr,
    input  logic [TW-1:0] al,
    output logic [OW-1:0] col_gap,
    output logic [OW-1:0] act_gap,
    output logic [OW-1:0] pre_gap,
    output logic          fam_err
);
    localparam int RW = 3 * OW + 1;

    fam_e          fam;
    logic          fam_ok;
    logic [TW-1:0] burst;
    logic [OW-1:0] col_c, act_c, pre_c;
    logic [RW-1:0] next_q, cur_q;

    // Decode family and burst duration in clocks.
    always_comb begin
        fam    = fam_e'(fam_sel);
        fam_ok = fam_valid(fam_sel);
        burst  = dbl_rate ? (bl >> 1) : bl;
    end

    ta_col_gap #(.TW(TW), .OW(OW)) u_col (
        .prev_wr(prev_wr), .cur_wr(cur_wr), .fam(fam), .grp_switch(grp_switch),
        .wl(wl), .rl(rl), .burst(burst),
        .tccd_s(tccd_s), .tccd_l(tccd_l), .twtr_s(twtr_s), .twtr_l(twtr_l),
        .trrd_s(trrd_s), .trrd_l(trrd_l),
        .col_gap(col_c), .act_gap(act_c)
    );

    ta_pre_gap #(.TW(TW), .OW(OW)) u_pre (
        .cur_wr(cur_wr), .fam(fam), .wl(wl), .burst(burst),
        .trtp(trtp), .twr(twr), .al(al), .pre_gap(pre_c)
    );

    // Force zeros and flag error on an unsupported family.
    always_comb begin
        if (fam_ok) begin
            next_q = {1'b0, col_c, act_c, pre_c};
        end else begin
            next_q = {1'b1, {(3 * OW){1'b0}}};
        end
    end

    ta_pipe_reg #(.W(RW)) u_reg (
        .clk(clk), .rst_n(rst_n), .d(next_q), .q(cur_q)
    );

    // Unpack the registered result.
    always_comb begin
        fam_err = cur_q[RW-1];
        col_gap = cur_q[3*OW-1:2*OW];
        act_gap = cur_q[2*OW-1:OW];
        pre_gap = cur_q[OW-1:0];
    end

endmodule

// File: rtl/ta_turnaround_chk.sv
// Checker for the turnaround calculator, attached by bind.
// Assumes timing inputs hold for at least one cycle around each check.
module ta_turnaround_chk #(
    parameter int TW = 6,
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prev_wr,
    input logic          cur_wr,
    input logic [2:0]    fam_sel,
    input logic          grp_switch,
    input logic [TW-1:0] tccd_s,
    input logic [TW-1:0] trrd_s,
    input logic [TW-1:0] trrd_l,
    input logic [TW-1:0] trtp,
    input logic [OW-1:0] col_gap,
    input logic [OW-1:0] act_gap,
    input logic [OW-1:0] pre_gap,
    input logic          fam_err
);
    p_same_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel == 3'd4 && prev_wr == cur_wr && grp_switch) |=> col_gap == OW'($past(tccd_s)));

    p_act_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel == 3'd4 && grp_switch) |=> act_gap == OW'($past(trrd_s)));

    p_rtp_std3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel == 3'd3 && !cur_wr) |=> pre_gap == OW'($past(trtp)));

    p_bad_family_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel > 3'd5) |=> (fam_err && col_gap == '0 && act_gap == '0 && pre_gap == '0));

    p_good_family_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel <= 3'd5) |=> !fam_err);

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!fam_err && col_gap == '0 && act_gap == '0 && pre_gap == '0));

    p_switch_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_sel <= 3'd5 && fam_sel != 3'd4) |=> act_gap == OW'($past(trrd_l)));

endmodule

bind ta_turnaround_calc ta_turnaround_chk #(.TW(TW), .OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prev_wr(prev_wr), .cur_wr(cur_wr),
    .fam_sel(fam_sel), .grp_switch(grp_switch), .tccd_s(tccd_s),
    .trrd_s(trrd_s), .trrd_l(trrd_l), .trtp(trtp),
    .col_gap(col_gap), .act_gap(act_gap), .pre_gap(pre_gap), .fam_err(fam_err)
);

// File: tb/ta_turnaround_calc_tb.sv
module ta_turnaround_calc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 6;
    localparam int OW = 8;

    typedef struct packed {
        logic       pw;
        logic       cw;
        logic [2:0] f;
        logic       sw;
        logic [7:0] c;
        logic [7:0] a;
        logic [7:0] p;
        logic       e;
    } vec_t;

    // Timing set: wl=5 rl=7 bl=8 double rate (burst 4) tccd 4/6 twtr 2/7
    // trrd 4/6 trtp=5 twr=12 al=3
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,3'd3,1'b0, 8'd6, 8'd6, 8'd5, 1'b0},  // R1 R5
        '{1'b1,1'b1,3'd3,1'b0, 8'd6, 8'd6, 8'd21,1'b0},  // R1 R6
        '{1'b1,1'b0,3'd3,1'b0, 8'd16,8'd6, 8'd5, 1'b0},  // R2
        '{1'b0,1'b1,3'd3,1'b0, 8'd8, 8'd6, 8'd21,1'b0},  // R3
        '{1'b1,1'b0,3'd4,1'b1, 8'd11,8'd4, 8'd5, 1'b0},  // R2 R4 short
        '{1'b1,1'b0,3'd4,1'b0, 8'd16,8'd6, 8'd5, 1'b0},  // R2 R4 long
        '{1'b0,1'b0,3'd4,1'b1, 8'd4, 8'd4, 8'd5, 1'b0},  // R1 short
        '{1'b1,1'b1,3'd4,1'b0, 8'd6, 8'd6, 8'd21,1'b0},  // R1 long
        '{1'b1,1'b0,3'd1,1'b0, 8'd17,8'd6, 8'd7, 1'b0},  // R2 +1, R5
        '{1'b0,1'b1,3'd1,1'b0, 8'd8, 8'd6, 8'd22,1'b0},  // R6 +1
        '{1'b1,1'b0,3'd5,1'b0, 8'd15,8'd6, 8'd4, 1'b0},  // R2 -1, R5
        '{1'b0,1'b1,3'd5,1'b1, 8'd8, 8'd6, 8'd20,1'b0},  // R6 -1, R10
        '{1'b0,1'b0,3'd0,1'b0, 8'd6, 8'd6, 8'd4, 1'b0},  // R5
        '{1'b1,1'b1,3'd0,1'b0, 8'd6, 8'd6, 8'd21,1'b0},  // R6
        '{1'b0,1'b0,3'd2,1'b0, 8'd6, 8'd6, 8'd10,1'b0},  // R5
        '{1'b1,1'b0,3'd2,1'b1, 8'd16,8'd6, 8'd10,1'b0},  // R10
        '{1'b0,1'b0,3'd6,1'b0, 8'd0, 8'd0, 8'd0, 1'b1},  // R8
        '{1'b1,1'b0,3'd7,1'b1, 8'd0, 8'd0, 8'd0, 1'b1}   // R8
    };

    logic          clk = 1'b0;
    logic          rst_n, prev_wr, cur_wr, grp_switch, dbl_rate;
    logic [2:0]    fam_sel;
    logic [TW-1:0] wl, rl, bl, tccd_s, tccd_l, twtr_s, twtr_l, trrd_s, trrd_l, trtp, twr, al;
    logic [OW-1:0] col_gap, act_gap, pre_gap;
    logic          fam_err;
    int            n_checks = 0;
    int            n_fail = 0;
    logic          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ta_turnaround_calc #(.TW(TW), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .prev_wr(prev_wr), .cur_wr(cur_wr),
        .fam_sel(fam_sel), .grp_switch(grp_switch), .dbl_rate(dbl_rate),
        .wl(wl), .rl(rl), .bl(bl), .tccd_s(tccd_s), .tccd_l(tccd_l),
        .twtr_s(twtr_s), .twtr_l(twtr_l), .trrd_s(trrd_s), .trrd_l(trrd_l),
        .trtp(trtp), .twr(twr), .al(al),
        .col_gap(col_gap), .act_gap(act_gap), .pre_gap(pre_gap), .fam_err(fam_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic apply(input logic pw, input logic cw, input logic [2:0] f, input logic sw);
        @(negedge clk);
        prev_wr = pw; cur_wr = cw; fam_sel = f; grp_switch = sw;
        @(negedge clk);
    endtask

    task automatic base_timing();
        wl = 6'd5; rl = 6'd7; bl = 6'd8; dbl_rate = 1'b1;
        tccd_s = 6'd4; tccd_l = 6'd6; twtr_s = 6'd2; twtr_l = 6'd7;
        trrd_s = 6'd4; trrd_l = 6'd6; trtp = 6'd5; twr = 6'd12; al = 6'd3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; prev_wr = 1'b0; cur_wr = 1'b0; fam_sel = 3'd3; grp_switch = 1'b0;
        base_timing();
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset col", int'(col_gap), 0);
        check("R9 reset pre", int'(pre_gap), 0);
        check("R9 reset err", int'(fam_err), 0);
        rst_n = 1'b1;

        // Table walk: R1..R6, R8, R10
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].pw, VECS[i].cw, VECS[i].f, VECS[i].sw);
            check($sformatf("R1-6 col vec%0d", i), int'(col_gap), int'(VECS[i].c));
            check($sformatf("R4 act vec%0d", i), int'(act_gap), int'(VECS[i].a));
            check($sformatf("R5/6 pre vec%0d", i), int'(pre_gap), int'(VECS[i].p));
            check($sformatf("R8 err vec%0d", i), int'(fam_err), int'(VECS[i].e));
        end

        // R10: switch toggled in family 3 leaves everything unchanged
        apply(1'b1, 1'b0, 3'd3, 1'b1);
        check("R10 col", int'(col_gap), 16);
        check("R10 act", int'(act_gap), 6);

        // R7: single rate, burst = 8; write-to-precharge 5+8+12
        dbl_rate = 1'b0;
        apply(1'b1, 1'b1, 3'd3, 1'b0);
        check("R7 pre single rate", int'(pre_gap), 25);
        apply(1'b0, 1'b1, 3'd3, 1'b0);
        check("R7 r2w single rate", int'(col_gap), 12);
        dbl_rate = 1'b1;

        // R5 small trtp corners: family 1 floor at zero, family 2 floor at 2
        trtp = 6'd1;
        apply(1'b0, 1'b0, 3'd1, 1'b0);
        check("R5 lp23 trtp floor", int'(pre_gap), 4);
        apply(1'b0, 1'b0, 3'd2, 1'b0);
        check("R5 std2 trtp floor", int'(pre_gap), 7);
        trtp = 6'd5;

        // R3 clamp: wl exceeds rl+burst+2
        wl = 6'd20;
        apply(1'b0, 1'b1, 3'd3, 1'b0);
        check("R3 clamp zero", int'(col_gap), 0);
        wl = 6'd5;

        // R9 one-cycle latency: output still holds old value before the edge
        apply(1'b1, 1'b1, 3'd3, 1'b0);
        prev_wr = 1'b1; cur_wr = 1'b0;
        #1;
        check("R9 latency hold", int'(col_gap), 6);
        @(negedge clk);
        check("R9 latency update", int'(col_gap), 16);

        // R9 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset col", int'(col_gap), 0);
        check("R9 mid reset pre", int'(pre_gap), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", int'(col_gap), 16);

        finish_run();
    end

endmodule